// File: doc/BRIEF.md
# Two's-Complement Adder-Subtractor with Overflow Detection

This block is a purely combinational 32-bit arithmetic unit. It adds or subtracts two two's-complement operands. A single mode input picks the operation. To subtract, the unit inverts every bit of the second operand and feeds a carry-in of one into the same ripple-carry adder. The unit therefore needs no separate subtractor. Alongside the 32-bit result it reports the raw carry out of the top bit and a signed overflow flag.

The carry chain is built hierarchically. One-bit full adders form 4-bit groups. Four groups form a 16-bit segment, and two segments make the full word, with the carry rippling from the low segment into the high one. A datapath uses the result as a wrapped 32-bit value and reads the carry and overflow outputs as condition flags. The carry is the unsigned view and the overflow is the signed view.

Top module: `addsub_unit`

## Requirements
- R1: With sub_i = 0 (add), sum_o equals the low 32 bits of a_i + b_i.
- R2: With sub_i = 1 (subtract), sum_o equals the low 32 bits of a_i + ~b_i + 1, i.e. a_i - b_i modulo 2^32.
- R3: carry_o is bit 32 of the 33-bit sum a_i + (sub_i ? ~b_i : b_i) + sub_i. When adding, this is 1 exactly when the unsigned sum exceeds 2^32-1. When subtracting, it is 1 exactly when a_i >= b_i unsigned.
- R4: When adding, ovf_o is 1 only if bit 31 of a_i equals bit 31 of b_i and bit 31 of sum_o differs from them.
- R5: When subtracting, ovf_o is 1 only if bit 31 of a_i differs from bit 31 of b_i and bit 31 of sum_o differs from bit 31 of a_i.
- R6: carry_o and ovf_o are independent. 0x7FFFFFFF + 1 gives sum 0x80000000, ovf_o = 1, carry_o = 0. 0xFFFFFFFF + 1 gives sum 0, ovf_o = 0, carry_o = 1.
- R7: Subtracting equal operands gives sum 0, ovf_o = 0 and carry_o = 1. For example, 0 - 0 behaves this way.
- R8: Boundary subtractions wrap. 0x80000000 - 1 gives 0x7FFFFFFF with ovf_o = 1. 0 - 0x80000000 gives 0x80000000 with ovf_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand (minuend when subtracting) |
| b_i | input | 32 | Second operand (subtrahend when subtracting) |
| sub_i | input | 1 | Mode: 0 add, 1 subtract |
| sum_o | output | 32 | Wrapped 32-bit result |
| carry_o | output | 1 | Carry out of bit 31 |
| ovf_o | output | 1 | Signed overflow flag |

## Verification
The assertions re-check every settled input combination. They compare the result and the carry against a wide behavioural sum, and they check the overflow flag against the sign-bit rule for the active mode. The ripple structure has to agree with arithmetic on every vector the bench applies. Only the bench's directed scenarios show that specific boundary operands produce the flag combinations expected of them: maximum positive plus one, minimum negative minus one, zero minus the minimum, and equal operands. The bench's signed and unsigned reference also checks that the flags follow arithmetic meaning and not merely the sign-bit formula.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;
endpackage

// File: rtl/as_full_adder.sv
module as_full_adder (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  logic p;
  assign p   = a_i ^ b_i;
  assign s_o = p ^ c_i;
  assign c_o = (a_i & b_i) | (c_i & p);
endmodule

// File: rtl/as_group.sv
module as_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] a_i,
  input  logic [GW-1:0] b_i,
  input  logic          c_i,
  output logic [GW-1:0] s_o,
  output logic          c_o
);
  logic [GW:0] c;
  assign c[0] = c_i;

  for (genvar k = 0; k < GW; k++) begin : g_bit
    as_full_adder u_fa (
      .a_i(a_i[k]),
      .b_i(b_i[k]),
      .c_i(c[k]),
      .s_o(s_o[k]),
      .c_o(c[k+1])
    );
  end

  assign c_o = c[GW];
endmodule

// File: rtl/as_segment.sv
module as_segment #(
  parameter int unsigned SW = 16,
  parameter int unsigned GW = 4
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  input  logic          c_i,
  output logic [SW-1:0] s_o,
  output logic          c_o
);
  localparam int unsigned NG = SW / GW;

  logic [NG:0] c;
  assign c[0] = c_i;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    as_group #(.GW(GW)) u_grp (
      .a_i(a_i[g*GW +: GW]),
      .b_i(b_i[g*GW +: GW]),
      .c_i(c[g]),
      .s_o(s_o[g*GW +: GW]),
      .c_o(c[g+1])
    );
  end

  assign c_o = c[NG];
endmodule

// File: rtl/as_ovf_detect.sv
module as_ovf_detect
  import addsub_pkg::*;
(
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic s_msb_i,
  input  op_e  op_i,
  output logic ovf_o
);
  always_comb begin
    if (op_i == OP_SUB) ovf_o = (a_msb_i != b_msb_i) && (s_msb_i != a_msb_i);
    else                ovf_o = (a_msb_i == b_msb_i) && (s_msb_i != a_msb_i);
  end
endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned SEG_W = 16,
  parameter int unsigned GRP_W = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             carry_o,
  output logic             ovf_o
);
  localparam int unsigned NSEG = WIDTH / SEG_W;

  op_e              op;
  logic [WIDTH-1:0] b_eff;
  logic [NSEG:0]    c;

  assign op    = op_e'(sub_i);
  assign b_eff = b_i ^ {WIDTH{sub_i}};  // invert B for subtract
  assign c[0]  = sub_i;                 // +1 completes two's complement

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    as_segment #(.SW(SEG_W), .GW(GRP_W)) u_seg (
      .a_i(a_i[s*SEG_W +: SEG_W]),
      .b_i(b_eff[s*SEG_W +: SEG_W]),
      .c_i(c[s]),
      .s_o(sum_o[s*SEG_W +: SEG_W]),
      .c_o(c[s+1])
    );
  end

  assign carry_o = c[NSEG];

  as_ovf_detect u_ovf (
    .a_msb_i(a_i[WIDTH-1]),
    .b_msb_i(b_i[WIDTH-1]),
    .s_msb_i(sum_o[WIDTH-1]),
    .op_i   (op),
    .ovf_o  (ovf_o)
  );
endmodule

// File: rtl/addsub_unit_chk.sv
module addsub_unit_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             sub_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             carry_o,
  input logic             ovf_o
);
  logic [WIDTH:0] wide_add;
  logic [WIDTH:0] wide_sub;
  logic           sa, sb, ss;

  always_comb begin
    wide_add = {1'b0, a_i} + {1'b0, b_i};
    wide_sub = {1'b0, a_i} - {1'b0, b_i};
    sa = a_i[WIDTH-1];
    sb = b_i[WIDTH-1];
    ss = sum_o[WIDTH-1];
    if (!sub_i) begin
      p_add_sum_r1: assert (sum_o == wide_add[WIDTH-1:0]);
      p_add_carry_r3: assert (carry_o == wide_add[WIDTH]);
      p_add_ovf_r4: assert (ovf_o == ((sa == sb) && (ss != sa)));
    end else begin
      p_sub_sum_r2: assert (sum_o == wide_sub[WIDTH-1:0]);
      p_sub_carry_r3: assert (carry_o == (a_i >= b_i));
      p_sub_ovf_r5: assert (ovf_o == ((sa != sb) && (ss != sa)));
    end
  end
endmodule

bind addsub_unit addsub_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .a_i(a_i), .b_i(b_i), .sub_i(sub_i),
  .sum_o(sum_o), .carry_o(carry_o), .ovf_o(ovf_o)
);

// File: tb/sim_addsub_unit.sv
`timescale 1ns/1ps
module sim_addsub_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] a, b, sum;
  logic        sub, carry, ovf;

  always #2.5 clk = ~clk;

  addsub_unit u0 (
    .a_i(a), .b_i(b), .sub_i(sub),
    .sum_o(sum), .carry_o(carry), .ovf_o(ovf)
  );

  typedef struct {
    logic [31:0] a;
    logic [31:0] b;
    logic        sub;
    logic [31:0] sum;
    logic        c;
    logic        v;
    string       tag;
  } item_t;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit drv_done = 1'b0;

  task automatic drive(input logic [31:0] ia, input logic [31:0] ib,
                       input logic is, input string tag);
    item_t it;
    longint sa, sb, sr;
    logic [32:0] w;
    @(negedge clk);
    sa = longint'($signed(ia));
    sb = longint'($signed(ib));
    sr = is ? sa - sb : sa + sb;
    if (is) w = {1'b0, ia} - {1'b0, ib};
    else    w = {1'b0, ia} + {1'b0, ib};
    it.a = ia; it.b = ib; it.sub = is;
    it.sum = w[31:0];
    it.c = is ? (ia >= ib) : w[32];
    it.v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    it.tag = tag;
    a = ia; b = ib; sub = is;
    q.push_back(it);
  endtask

  // monitor: outputs settled half a cycle after the negedge drive
  always @(posedge clk) begin
    if (rst_ni && q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      n_cmp++;
      if (sum !== e.sum) begin
        n_bad++;
        $display("FAIL %s %s sum: a=%h b=%h got %h exp %h", e.tag,
                 e.sub ? "R2" : "R1", e.a, e.b, sum, e.sum);
      end
      n_cmp++;
      if (carry !== e.c) begin
        n_bad++;
        $display("FAIL %s R3 carry: a=%h b=%h sub=%0b got %0b exp %0b",
                 e.tag, e.a, e.b, e.sub, carry, e.c);
      end
      n_cmp++;
      if (ovf !== e.v) begin
        n_bad++;
        $display("FAIL %s %s ovf: a=%h b=%h got %0b exp %0b", e.tag,
                 e.sub ? "R5" : "R4", e.a, e.b, ovf, e.v);
      end
    end
  end

  initial begin
    a = '0; b = '0; sub = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // reset-state / first vector: 0 + 0 (R1)
    drive(32'h0, 32'h0, 1'b0, "R1");
    // R6: flags independent
    drive(32'h7FFF_FFFF, 32'h1, 1'b0, "R6");
    drive(32'hFFFF_FFFF, 32'h1, 1'b0, "R6");
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R4");
    drive(32'h0000_1111, 32'h0000_2222, 1'b0, "R1");
    drive(32'hFFFF_FFFC, 32'hFFFF_FFFD, 1'b0, "R4");
    // R7: equal operands
    drive(32'h0, 32'h0, 1'b1, "R7");
    drive(32'hA5A5_A5A5, 32'hA5A5_A5A5, 1'b1, "R7");
    // R8: boundary subtractions
    drive(32'h8000_0000, 32'h1, 1'b1, "R8");
    drive(32'h0, 32'h8000_0000, 1'b1, "R8");
    drive(32'h1, 32'hFFFF_FFFF, 1'b1, "R5");
    drive(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, "R5");
    drive(32'h1111, 32'h2222, 1'b1, "R2");
    for (int i = 0; i < 400; i++) begin
      drive($urandom, $urandom, i[0], "RND");
    end
    // carry-ripple across the segment boundary
    drive(32'h0000_FFFF, 32'h0000_0001, 1'b0, "R1");
    drive(32'h0001_0000, 32'h0000_0001, 1'b1, "R2");
    drv_done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!(drv_done && q.size() == 0) && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (cyc >= 5000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
    end
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule